// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital side of an 8-bit successive-approximation analog-to-digital converter. A CPU reaches it through two byte registers: a status/control register (channel code, enable, clock-source select, conversion-complete flag) and a read-only result register. The sample-and-hold, the DAC, the comparator and the analog multiplexer all sit outside the block. The controller drives a channel select, a one-cycle hold strobe and a trial code to them. It reads back one comparator bit.

Each conversion has one sample cycle and then eight compare cycles. The compare cycles decide the code from the most significant bit down. The finished code goes into the result register and the complete flag is set. The controller then starts the next conversion on the same channel at once, so the result keeps refreshing. Any write to the control register aborts the conversion in progress, clears the flag and starts again on the channel just written.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset the control register reads 0x00 (channel 0, enable 0, clock select 0, flag 0), the result reads 0x00, and no hold strobe is issued.
- R2: The control register reads as {flag[7], clksel[6], enable[5], 0[4], channel[3:0]}. Bit 4 always reads 0, and writing bit 7 cannot set the flag.
- R3: A control write with enable=1 raises the hold strobe for exactly the cycle after the write. Eight compare cycles follow. The trial code in the compare step for bit i equals the bits already decided above i, with bit i set and all lower bits clear, so the first trial is 0x80.
- R4: A comparator input of 1 (held input at or above the trial) keeps the trial bit, and 0 clears it. With an ideal comparator the result equals the code of the held input, for every value from 0 to 255.
- R5: The result register changes only on the clock edge that decides bit 0, which is nine cycles after the starting write. The flag is set on that same edge.
- R6: Any control write clears the flag and discards the conversion in progress. The next result comes from the newly written channel, and the partial code never reaches the result register.
- R7: After a completion the hold strobe is raised in the very next cycle, on the same channel. The flag stays set until the next control write, and each later completion refreshes the result.
- R8: A control write with enable=0 clears the flag and leaves the controller idle. No hold strobe is issued and the result keeps its last value.
- R9: A write to the result address (addr=0) has no effect: the result, the control register and the timing of the running conversion are all unchanged.
- R10: The channel select output equals the channel code. Codes 0 to 7 pick external inputs, 8 the high reference, 9 the low reference and 10 the midpoint. With an ideal comparator these three give 0xFF, 0x00 and 0x80.
- R11: The clock-select output follows control bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| addr | input | 1 | Register select: 1 = status/control, 0 = result |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Read data of the addressed register |
| mux_sel | output | 4 | Analog channel select |
| sample_hold | output | 1 | Hold strobe, high during the sample cycle |
| trial_code | output | 8 | Code presented to the DAC |
| cmp_hi | input | 1 | Comparator: held input is at or above the DAC level |
| rc_clk_sel | output | 1 | Internal clock-source select |

## Verification
The assertions check on every cycle that:
- the result moves only on the edge that decides the last bit;
- a control write always leaves the flag clear;
- the first trial after a hold strobe is the midscale code;
- the strobe stays low while the converter is disabled;
- a completion sets the flag and begins a new sample.

Only the bench scenarios can show that codes are correct. They cover an exhaustive sweep of the input values with an ideal comparator, the exact trial sequence, aborts in mid-conversion, refresh in continuous mode and the reference channels.

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic [3:0]       mux_sel,
  output logic             sample_hold,
  output logic [RES_W-1:0] trial_code,
  input  logic             cmp_hi,
  output logic             rc_clk_sel
);
  localparam int BW = $clog2(RES_W);
  localparam logic [BW-1:0] TOP_BIT = BW'(RES_W - 1);

  typedef enum logic [1:0] {S_IDLE, S_SAMP, S_CMP} st_t;

  st_t              state_q;
  logic [BW-1:0]    bit_q;
  logic [RES_W-1:0] sar_q, res_q;
  logic [3:0]       chan_q;
  logic             en_q, rc_q, coco_q;

  wire ctrl_wr = wr_en & addr;
  wire [RES_W-1:0] step = RES_W'(1) << bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      bit_q   <= TOP_BIT;
      sar_q   <= '0;
      res_q   <= '0;
      chan_q  <= '0;
      en_q    <= 1'b0;
      rc_q    <= 1'b0;
      coco_q  <= 1'b0;
    end else if (ctrl_wr) begin
      chan_q  <= wdata[3:0];
      en_q    <= wdata[5];
      rc_q    <= wdata[6];
      coco_q  <= 1'b0;
      sar_q   <= '0;
      bit_q   <= TOP_BIT;
      state_q <= wdata[5] ? S_SAMP : S_IDLE;
    end else begin
      case (state_q)
        S_SAMP: begin
          sar_q   <= '0;
          bit_q   <= TOP_BIT;
          state_q <= S_CMP;
        end
        S_CMP: begin
          sar_q[bit_q] <= cmp_hi;
          if (bit_q == '0) begin
            res_q   <= {sar_q[RES_W-1:1], cmp_hi};
            coco_q  <= 1'b1;
            state_q <= S_SAMP;
          end else begin
            bit_q <= bit_q - 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign trial_code  = (state_q == S_CMP) ? (sar_q | step) : '0;
  assign sample_hold = (state_q == S_SAMP);
  assign mux_sel     = chan_q;
  assign rc_clk_sel  = rc_q;
  assign rdata       = addr ? {coco_q, rc_q, en_q, 1'b0, chan_q} : 8'(res_q);
endmodule

module sar_adc_ctrl_chk #(
  parameter int RES_W = 8,
  parameter int BW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_wr,
  input logic             in_cmp,
  input logic [BW-1:0]    bit_q,
  input logic [RES_W-1:0] res_q,
  input logic             coco_q,
  input logic             en_q,
  input logic             rc_q,
  input logic             sample_hold,
  input logic [RES_W-1:0] trial_code
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n |=> (!en_q && !rc_q && !coco_q && res_q == '0));

  assert_first_trial_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_hold && !ctrl_wr) |=> trial_code == (RES_W'(1) << (RES_W - 1)));

  assert_result_only_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_q) |-> $past(in_cmp && bit_q == '0 && !ctrl_wr));

  assert_write_clears_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !coco_q);

  assert_restart_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cmp && bit_q == '0 && !ctrl_wr) |=> (coco_q && sample_hold));

  assert_idle_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !sample_hold);
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.RES_W(RES_W), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(wr_en & addr), .in_cmp(state_q == S_CMP),
  .bit_q(bit_q), .res_q(res_q), .coco_q(coco_q), .en_q(en_q), .rc_q(rc_q),
  .sample_hold(sample_hold), .trial_code(trial_code));

// File: tb/sar_adc_ctrl_bench.sv
`timescale 1ns/1ps
module sar_adc_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic addr = 1'b1;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [3:0] mux_sel;
  logic sample_hold;
  logic [7:0] trial_code;
  logic cmp_hi;
  logic rc_clk_sel;

  logic [7:0] vin [8];
  logic [7:0] held = 8'h00;
  int checks = 0;
  int errors = 0;
  int strobes = 0;

  always #5 clk = ~clk;

  sar_adc_ctrl u_sar_adc_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .mux_sel(mux_sel), .sample_hold(sample_hold),
    .trial_code(trial_code), .cmp_hi(cmp_hi), .rc_clk_sel(rc_clk_sel));

  function automatic logic [7:0] level(input logic [3:0] ch);
    if (ch < 4'd8) return vin[ch[2:0]];
    if (ch == 4'd8) return 8'hFF;
    if (ch == 4'd10) return 8'h80;
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (sample_hold) begin
      held <= level(mux_sel);
      strobes <= strobes + 1;
    end
  end
  assign cmp_hi = (held >= trial_code);

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = 1'b1;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_res(output logic [7:0] v);
    addr = 1'b0; #1 v = rdata; addr = 1'b1; #1;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r, prev;
    for (int i = 0; i < 8; i++) vin[i] = 8'h00;
    step(3);
    #1 check(rdata == 8'h00, "R1 ctrl", rdata, 0);
    rd_res(r); check(r == 8'h00, "R1 result", r, 0);
    check(strobes == 0 && sample_hold == 0, "R1 strobe", strobes, 0);
    rst_n = 1'b1;
    step(3);
    check(strobes == 0, "R1 idle", strobes, 0);

    // R2 readback: bit 4 and bit 7 written high
    wr(1'b1, 8'h93);
    #1 check(rdata == 8'h03, "R2 readback", rdata, 8'h03);
    check(rc_clk_sel == 1'b0, "R11 off", rc_clk_sel, 0);
    wr(1'b1, 8'h40);
    #1 check(rc_clk_sel == 1'b1 && rdata == 8'h40, "R11 on", rdata, 8'h40);
    step(4);
    check(strobes == 0, "R8 no run when disabled", strobes, 0);

    // R3 trial sequence
    vin[4] = 8'hA5;
    wr(1'b1, 8'h24);
    check(sample_hold == 1'b1 && trial_code == 8'h00, "R3 sample cycle", trial_code, 0);
    for (int k = 7; k >= 0; k--) begin
      int e;
      step(1);
      e = ((8'hA5 & ~((1 << (k + 1)) - 1)) & 8'hFF) | (1 << k);
      check(trial_code == 8'(e) && !sample_hold, "R3 trial", trial_code, e);
    end
    step(1);
    rd_res(r);
    check(r == 8'hA5, "R4 result", r, 8'hA5);
    check(sample_hold == 1'b1, "R7 immediate restart", sample_hold, 1);

    // R4/R5 exhaustive sweep with exact latency
    for (int v = 0; v < 256; v++) begin
      logic [7:0] rb;
      rd_res(prev);
      vin[v % 8] = 8'(v);
      wr(1'b1, 8'h20 | 8'(v % 8));
      step(8);
      rd_res(rb);
      check(rb == prev && rdata[7] == 1'b0, "R5 no early update", rb, prev);
      step(1);
      rd_res(rb);
      check(rb == 8'(v) && rdata[7] == 1'b1, "R4 sweep", rb, v);
    end

    // R7 continuous refresh
    vin[2] = 8'h37;
    wr(1'b1, 8'h22);
    step(9);
    rd_res(r); check(r == 8'h37, "R7 first", r, 8'h37);
    vin[2] = 8'hC4;
    step(8);
    rd_res(r); check(r == 8'h37 && rdata[7], "R7 hold until done", r, 8'h37);
    step(1);
    rd_res(r); check(r == 8'hC4 && rdata[7], "R7 refresh", r, 8'hC4);

    // R6 abort
    vin[3] = 8'h11; vin[5] = 8'hEE;
    wr(1'b1, 8'h23);
    step(4);
    rd_res(prev);
    wr(1'b1, 8'h25);
    #1 check(rdata[7] == 1'b0, "R6 flag cleared", rdata, 8'h25);
    step(8);
    rd_res(r); check(r == prev, "R6 partial discarded", r, prev);
    step(1);
    rd_res(r); check(r == 8'hEE, "R6 new channel", r, 8'hEE);
    check(mux_sel == 4'd5, "R10 select", mux_sel, 5);

    // R9 write to result address
    vin[6] = 8'h5A;
    wr(1'b1, 8'h26);
    step(3);
    wr(1'b0, 8'hFF);
    #1 check(rdata == 8'h26, "R9 ctrl unchanged", rdata, 8'h26);
    step(4);
    rd_res(r); check(r == 8'hEE, "R9 result unchanged", r, 8'hEE);
    step(1);
    rd_res(r); check(r == 8'h5A, "R9 timing kept", r, 8'h5A);

    // R10 references
    wr(1'b1, 8'h28); step(9);
    rd_res(r); check(r == 8'hFF, "R10 high", r, 8'hFF);
    wr(1'b1, 8'h29); step(9);
    rd_res(r); check(r == 8'h00, "R10 low", r, 0);
    wr(1'b1, 8'h2A); step(9);
    rd_res(r); check(r == 8'h80, "R10 mid", r, 8'h80);

    // R8 disable
    step(2);
    wr(1'b1, 8'h01);
    begin
      int s0;
      s0 = strobes;
      #1 check(rdata == 8'h01, "R8 flag cleared", rdata, 1);
      step(20);
      check(strobes == s0, "R8 no strobe", strobes, s0);
      rd_res(r); check(r == 8'h80, "R8 result held", r, 8'h80);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule